// File: doc/BRIEF.md
# Registered Four-Function Arithmetic Logic Unit

This block is a small arithmetic logic unit with flip-flops on both sides of its combinational core. On a rising clock edge it captures two operand words, a carry bit and a two-bit function code. From the captured values it computes four results side by side: a sum with carry, a bitwise AND, a bitwise OR and a bitwise NOR. The function code drives a four-way selector, and the chosen word is captured into the result register on the next edge.

The operand width is a parameter and defaults to four bits. The adder can be built in one of two ways. One is a ripple chain of replicated one-bit slices, where each slice also produces that bit's logic results. The other is a plain arithmetic expression that leaves the adder's form to the synthesis tool. The carry out of the top bit is discarded. Only the low word of the sum reaches the result.

Top module: `qalu_top`

## Requirements
- R1: With function code 2'b00 the result is (A + B + carry-in) reduced modulo 2^WIDTH.
- R2: With function code 2'b01 the result is the bitwise AND of A and B.
- R3: With function code 2'b10 the result is the bitwise OR of A and B.
- R4: With function code 2'b11 the result is the bitwise NOR of A and B, meaning every bit of A|B is inverted.
- R5: For function codes 2'b01, 2'b10 and 2'b11 the carry-in has no effect on the result.
- R6: A set of inputs present before rising edge k appears on the result output after rising edge k+1. The output is still unchanged after edge k alone.
- R7: While the synchronous active-high reset is high at a rising edge, every input register and the result register load zero. The first result after reset is released therefore comes from all-zero operands.
- R8: The function code is captured together with its operands. A new code and new operands on every cycle each yield the result for their own pairing.
- R9: No carry out is produced. A sum that overflows wraps, so 15+1+0 gives 0 and 15+15+1 gives 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into the addition |
| op_i | input | 2 | Function code: 00 add, 01 AND, 10 OR, 11 NOR |
| y_o | output | WIDTH | Registered result |

## Verification
Each result is due on the output two rising edges after its inputs are driven. The first edge loads the input registers and the second loads the result register. The bench drives a new vector on every falling edge and keeps a two-deep queue of expected values. On each falling edge it compares the output with the entry queued two falling edges earlier. A separate directed step checks the output one edge after a change, where it must still show the old value, and again one edge later. A mid-run reset is checked at the edge that applies it and at the first edge after its release.

// File: rtl/qalu_pkg.sv
package qalu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_AND = 2'b01,
      OP_OR  = 2'b10,
      OP_NOR = 2'b11
   } qalu_op_e;

   localparam int unsigned OP_BITS = 2;

endpackage

// File: rtl/qalu_inreg.sv
module qalu_inreg
   import qalu_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [WIDTH-1:0]     a_d,
   input  logic [WIDTH-1:0]     b_d,
   input  logic                 cin_d,
   input  logic [OP_BITS-1:0]   op_d,
   output logic [WIDTH-1:0]     a_q,
   output logic [WIDTH-1:0]     b_q,
   output logic                 cin_q,
   output logic [OP_BITS-1:0]   op_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q   <= '0;
         b_q   <= '0;
         cin_q <= 1'b0;
         op_q  <= '0;
      end else begin
         a_q   <= a_d;
         b_q   <= b_d;
         cin_q <= cin_d;
         op_q  <= op_d;
      end
   end

endmodule

// File: rtl/qalu_slice.sv
module qalu_slice (
   input  logic x_i,
   input  logic z_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o,
   output logic and_o,
   output logic or_o,
   output logic nor_o
);

   logic half;

   always_comb begin
      half  = x_i ^ z_i;
      s_o   = half ^ c_i;
      c_o   = (x_i & z_i) | (half & c_i);
      and_o = x_i & z_i;
      or_o  = x_i | z_i;
      nor_o = ~(x_i | z_i);
   end

endmodule

// File: rtl/qalu_core.sv
module qalu_core #(
   parameter int unsigned WIDTH      = 4,
   parameter bit          RIPPLE_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             ci_i,
   output logic [WIDTH-1:0] sum_o,
   output logic [WIDTH-1:0] and_o,
   output logic [WIDTH-1:0] or_o,
   output logic [WIDTH-1:0] nor_o
);

   localparam int unsigned CHAIN = WIDTH + 1;

   if (RIPPLE_ADD) begin : g_ripple
      logic [CHAIN-1:0] carry;
      assign carry[0] = ci_i;

      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         qalu_slice u_slice (
            .x_i   (a_i[i]),
            .z_i   (b_i[i]),
            .c_i   (carry[i]),
            .s_o   (sum_o[i]),
            .c_o   (carry[i+1]),
            .and_o (and_o[i]),
            .or_o  (or_o[i]),
            .nor_o (nor_o[i])
         );
      end

      // R1
      add_chain_chk: assert property (@(posedge clk) disable iff (rst)
         {carry[WIDTH], sum_o} ==
         ({1'b0, a_i} + {1'b0, b_i} + CHAIN'(ci_i)));
   end else begin : g_flat
      assign sum_o = a_i + b_i + WIDTH'(ci_i);
      assign and_o = a_i & b_i;
      assign or_o  = a_i | b_i;
      assign nor_o = ~(a_i | b_i);

      // R4
      nor_flat_chk: assert property (@(posedge clk) disable iff (rst)
         (nor_o & or_o) == '0);
   end

endmodule

// File: rtl/qalu_mux.sv
module qalu_mux
   import qalu_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [OP_BITS-1:0] sel_i,
   input  logic [WIDTH-1:0]   sum_i,
   input  logic [WIDTH-1:0]   and_i,
   input  logic [WIDTH-1:0]   or_i,
   input  logic [WIDTH-1:0]   nor_i,
   output logic [WIDTH-1:0]   res_o
);

   always_comb begin
      case (sel_i)
         OP_ADD:  res_o = sum_i;
         OP_AND:  res_o = and_i;
         OP_OR:   res_o = or_i;
         default: res_o = nor_i;
      endcase
   end

endmodule

// File: rtl/qalu_top.sv
module qalu_top
   import qalu_pkg::*;
#(
   parameter int unsigned WIDTH      = 4,
   parameter bit          RIPPLE_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   input  logic [1:0]       op_i,
   output logic [WIDTH-1:0] y_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("qalu_top: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0]   a_q, b_q;
   logic               cin_q;
   logic [OP_BITS-1:0] op_q;
   logic [WIDTH-1:0]   sum_w, and_w, or_w, nor_w, res_w;

   qalu_inreg #(.WIDTH(WIDTH)) u_inreg (
      .clk   (clk),
      .rst   (rst),
      .a_d   (a_i),
      .b_d   (b_i),
      .cin_d (cin_i),
      .op_d  (op_i),
      .a_q   (a_q),
      .b_q   (b_q),
      .cin_q (cin_q),
      .op_q  (op_q)
   );

   qalu_core #(.WIDTH(WIDTH), .RIPPLE_ADD(RIPPLE_ADD)) u_core (
      .clk   (clk),
      .rst   (rst),
      .a_i   (a_q),
      .b_i   (b_q),
      .ci_i  (cin_q),
      .sum_o (sum_w),
      .and_o (and_w),
      .or_o  (or_w),
      .nor_o (nor_w)
   );

   qalu_mux #(.WIDTH(WIDTH)) u_mux (
      .sel_i (op_q),
      .sum_i (sum_w),
      .and_i (and_w),
      .or_i  (or_w),
      .nor_i (nor_w),
      .res_o (res_w)
   );

   always_ff @(posedge clk) begin
      if (rst) y_o <= '0;
      else     y_o <= res_w;
   end

   // R7
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (y_o == '0));

   // R1
   add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (op_q == OP_ADD) |=>
      (y_o == WIDTH'($past(a_q) + $past(b_q) + WIDTH'($past(cin_q)))));

   // R2
   and_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (op_q == OP_AND) |=>
      (((y_o & ~$past(a_q)) == '0) && ((y_o & ~$past(b_q)) == '0) &&
       ((y_o | ~($past(a_q) & $past(b_q))) == '1)));

   // R3
   or_cover_chk: assert property (@(posedge clk) disable iff (rst)
      (op_q == OP_OR) |=>
      (((y_o & $past(a_q)) == $past(a_q)) && ((y_o & $past(b_q)) == $past(b_q)) &&
       ((y_o & ~($past(a_q) | $past(b_q))) == '0)));

   // R4
   nor_excl_chk: assert property (@(posedge clk) disable iff (rst)
      (op_q == OP_NOR) |=>
      (((y_o & ($past(a_q) | $past(b_q))) == '0) &&
       ((y_o | $past(a_q) | $past(b_q)) == '1)));

endmodule

// File: tb/qalu_top_tb.sv
`timescale 1ns/1ps
module qalu_top_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] a = '0, b = '0;
   logic       cin = 1'b0;
   logic [1:0] op = '0;
   logic [3:0] y;

   int checks = 0;
   int errors = 0;

   logic [3:0] exp1, exp2;
   string      tag1, tag2;
   bit         vld1 = 1'b0, vld2 = 1'b0;

   always #2.5 clk = ~clk;

   qalu_top #(.WIDTH(4), .RIPPLE_ADD(1'b1)) u_dut (
      .clk   (clk),
      .rst   (rst),
      .a_i   (a),
      .b_i   (b),
      .cin_i (cin),
      .op_i  (op),
      .y_o   (y)
   );

   function automatic logic [3:0] model(logic [3:0] x, logic [3:0] z,
                                        logic c, logic [1:0] f);
      logic [4:0] s;
      case (f)
         2'b00: begin s = {1'b0, x} + {1'b0, z} + {4'b0, c}; return s[3:0]; end
         2'b01: return x & z;
         2'b10: return x | z;
         default: return ~(x | z);
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] x, logic [3:0] z,
                                    logic c, logic [1:0] f);
      if (f == 2'b00) return ((5'(x) + 5'(z) + 5'(c)) > 5'd15) ? "R9" : "R1";
      if (c) return "R5";
      case (f)
         2'b01: return "R2";
         2'b10: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(logic [3:0] got, logic [3:0] want, string req);
      checks++;
      if (got !== want) begin
         errors++;
         $display("FAIL %s: y=%0h expected %0h at %0t", req, got, want, $time);
      end
   endtask

   // drive one vector per falling edge, compare against the vector two edges back
   task automatic step(logic [3:0] x, logic [3:0] z, logic c, logic [1:0] f,
                       string req);
      @(negedge clk);
      if (vld2) check(y, exp2, tag2);
      exp2 = exp1; tag2 = tag1; vld2 = vld1;
      exp1 = model(x, z, c, f);
      tag1 = (req == "") ? tag_of(x, z, c, f) : req;
      vld1 = 1'b1;
      a = x; b = z; cin = c; op = f;
   endtask

   task automatic drain();
      step(4'h0, 4'h0, 1'b0, 2'b00, "R1");
      step(4'h0, 4'h0, 1'b0, 2'b00, "R1");
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed_w;
      seed_w = $urandom(32'h5A17);
      rst = 1'b1;
      a = 4'hF; b = 4'hA; cin = 1'b1; op = 2'b11;
      repeat (3) @(negedge clk);
      // R7: reset state
      check(y, 4'h0, "R7");
      rst = 1'b0;
      @(negedge clk);
      // R7: first result comes from cleared input registers
      check(y, 4'h0, "R7");
      @(negedge clk);
      check(y, 4'h0, "R4");

      // directed wrap cases R9
      step(4'hF, 4'h1, 1'b0, 2'b00, "R9");
      step(4'hF, 4'hF, 1'b1, 2'b00, "R9");
      step(4'h8, 4'h8, 1'b0, 2'b00, "R9");
      // carry-in ignored by logic ops R5
      step(4'h6, 4'hC, 1'b1, 2'b01, "R5");
      step(4'h6, 4'hC, 1'b1, 2'b10, "R5");
      step(4'h0, 4'h0, 1'b1, 2'b11, "R5");
      drain();

      // exhaustive sweep, opcode changes every cycle (R8)
      for (int f = 0; f < 4; f++)
         for (int c = 0; c < 2; c++)
            for (int x = 0; x < 16; x++)
               for (int z = 0; z < 16; z++)
                  step(4'(x), 4'(z), 1'(c), 2'((f + x + z) % 4), "");
      drain();

      // random mix, every pairing checked against its own code (R8)
      for (int i = 0; i < 600; i++)
         step(4'($urandom), 4'($urandom), 1'($urandom), 2'($urandom), "R8");
      drain();

      // latency R6
      vld1 = 1'b0; vld2 = 1'b0;
      @(negedge clk);
      a = 4'h3; b = 4'h5; cin = 1'b0; op = 2'b10;
      repeat (2) @(negedge clk);
      check(y, 4'h7, "R6");
      a = 4'h9; b = 4'h4; cin = 1'b1; op = 2'b00;
      @(negedge clk);
      check(y, 4'h7, "R6");
      @(negedge clk);
      check(y, 4'hE, "R6");

      // mid-run reset R7
      a = 4'hC; b = 4'h3; cin = 1'b0; op = 2'b10;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(y, 4'h0, "R7");
      rst = 1'b0;
      a = 4'h5; b = 4'h2; op = 2'b10;
      @(negedge clk);
      check(y, 4'h0, "R7");
      @(negedge clk);
      check(y, 4'h7, "R7");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule